// File: doc/BRIEF.md
# Prescaled Timer with Compare Reset

This block is the free-running time base of a capture/compare timer. A 16-bit up-counter advances from the module clock through a prescaler whose divide factor is chosen by a 3-bit select code. A newly chosen factor is not applied at once: it waits until the prescaler has rolled back to all zeros, so the counter never sees a short or long first period.

Optionally the counter can be cleared by the compare value of the highest-numbered channel, which turns the 16-bit range into a programmable modulus. An overflow flag records the natural wrap from all ones to zero. An 8-bit channel flag register collects event pulses from the channel logic, can be cleared by writing ones, and drives a masked interrupt request. The per-channel capture and compare logic and the register address decode live outside this block; it only sees their set pulses and decoded write strobes.

Top module: `presc_timer`

## Requirements
- R1: After reset the counter is 0x0000, the overflow flag is 0, all channel flags are 0 and the interrupt request is 0.
- R2: The prescale select code maps 0,1,2,3,4,5,6,7 to divide factors 1,2,4,8,16,32,32,32; once applied, the counter advances exactly 64/factor times in any 64 consecutive clocks with the enable high.
- R3: The prescaler is a 5-bit counter that runs every clock from 0 after reset; a changed select code is applied only at the clock edge where that prescaler is zero, and until then the old factor stays in use.
- R4: With compare reset enabled, a counter tick taken while the counter equals the compare value loads 0x0000 instead of incrementing.
- R5: With compare reset enabled and a compare value of 0x0000, the counter stays at 0x0000.
- R6: With compare reset enabled and a compare value of 0xFFFF, the step from 0xFFFF to 0x0000 leaves the overflow flag unchanged.
- R7: With compare reset disabled, a tick at 0xFFFF wraps the counter to 0x0000 and sets the overflow flag on that same edge.
- R8: An overflow write strobe with data bit 7 set clears the overflow flag; with bit 7 clear it leaves the flag as it is; a set event in the same cycle wins over the clear.
- R9: Channel flag bit n (bit 7 for channel 7 down to bit 0 for channel 0) is set by a pulse on set input n; a flag write strobe clears every flag whose data bit is 1, leaves flags with a 0 data bit unchanged, and a set pulse in the same cycle wins over the clear.
- R10: The interrupt request is high exactly when at least one channel flag is set whose interrupt enable bit is also set.
- R11: While the timer enable is low the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timerEn | input | 1 | Counter advance enable |
| prescaleSel | input | 3 | Prescale select code |
| cmpResetEn | input | 1 | Enable counter clear on compare match |
| cmpValue | input | 16 | Compare value of the highest channel |
| chFlagSet | input | 8 | One-cycle set pulses, one per channel |
| chIntEn | input | 8 | Per-channel interrupt enables |
| flagWrEn | input | 1 | Write strobe for the channel flag register |
| ovfWrEn | input | 1 | Write strobe for the overflow flag register |
| wrData | input | 8 | Write data; ones clear flags |
| count | output | 16 | Current counter value |
| ovfFlag | output | 1 | Timer overflow flag |
| chFlags | output | 8 | Channel flag register |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions assume the compare value and the compare-reset enable are held steady around a match, since the properties relate the value seen on the matching edge to the count one cycle later; the bench changes them only while the block is in reset or while the counter is far from the match. They also assume a wrap-time overflow check is not overlaid by a simultaneous clear write, so the bench issues overflow writes only after wraps have completed. Prescaler deferral is checked by timing the select change against a bench-side count of edges since reset, which keeps every switch clear of the prescaler's zero point.

// File: rtl/presc_timer_pkg.sv
package presc_timer_pkg;

  // Strobes from the control section to the datapath, valid for one clock.
  typedef struct packed {
    logic advance;    // counter takes a tick this edge
    logic zeroCount;  // tick loads zero instead of incrementing
    logic setOvf;     // tick is a natural wrap that raises overflow
  } tmrStrobe_t;

endpackage

// File: rtl/presc_timer_ctrl.sv
module presc_timer_ctrl
  import presc_timer_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SEL_W      = 3,
  parameter int PRE_STAGES = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             timerEn,
  input  logic [SEL_W-1:0] prescaleSel,
  input  logic             cmpResetEn,
  input  logic [CNT_W-1:0] cmpValue,
  input  logic [CNT_W-1:0] count,
  output tmrStrobe_t       strobe
);

  localparam int PRE_W = PRE_STAGES;
  localparam int N_W   = $clog2(PRE_STAGES + 1);

  logic [PRE_W-1:0] presc;
  logic [N_W-1:0]   activeN;
  logic [N_W-1:0]   reqN;
  logic [PRE_W-1:0] stageMask;
  logic             prescZero;
  logic             tickPoint;
  logic             atCompare;

  // Codes beyond the deepest stage saturate at the full prescaler depth.
  assign reqN = (int'(prescaleSel) > PRE_STAGES) ? N_W'(PRE_STAGES) : N_W'(prescaleSel);

  // Free-running prescaler.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) presc <= '0;
    else       presc <= presc + PRE_W'(1);
  end

  assign prescZero = (presc == '0);

  // Stage count is sampled only when every prescaler stage is zero.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          activeN <= '0;
    else if (prescZero) activeN <= reqN;
  end

  // Mask of the low activeN prescaler bits.
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign stageMask[i] = (N_W'(i) < activeN);
  end

  assign tickPoint = ((presc & stageMask) == '0);
  assign atCompare = cmpResetEn && (count == cmpValue);

  always_comb begin
    strobe           = '0;
    strobe.advance   = timerEn && tickPoint;
    strobe.zeroCount = strobe.advance && atCompare;
    strobe.setOvf    = strobe.advance && !atCompare && (count == '1);
  end

  // A new stage count may only appear right after the prescaler was zero.
  AST_SEL_DEFERRED: assert property (@(posedge clk) disable iff (!rstN)
    (activeN != $past(activeN)) |-> ($past(presc) == '0)); // R3

endmodule

// File: rtl/presc_timer_dp.sv
module presc_timer_dp
  import presc_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic [NUM_CH-1:0] chFlagSet,
  input  logic [NUM_CH-1:0] chIntEn,
  input  logic              flagWrEn,
  input  logic              ovfWrEn,
  input  logic [NUM_CH-1:0] wrData,
  output logic [CNT_W-1:0]  count,
  output logic              ovfFlag,
  output logic [NUM_CH-1:0] chFlags,
  output logic              irq
);

  localparam int CLR_BIT = NUM_CH - 1;

  logic [NUM_CH-1:0] clrMask;
  logic              ovfClr;

  // Counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 count <= '0;
    else if (strobe.zeroCount) count <= '0;
    else if (strobe.advance)   count <= count + CNT_W'(1);
  end

  // Overflow flag: set has priority over a write-one-to-clear.
  assign ovfClr = ovfWrEn && wrData[CLR_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ovfFlag <= 1'b0;
    else if (strobe.setOvf) ovfFlag <= 1'b1;
    else if (ovfClr)        ovfFlag <= 1'b0;
  end

  // Channel flags: per-bit clear by writing ones, set pulses win.
  assign clrMask = flagWrEn ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chFlags <= '0;
    else       chFlags <= (chFlags & ~clrMask) | chFlagSet;
  end

  assign irq = |(chFlags & chIntEn);

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    (|chFlagSet) |=> ((chFlags & $past(chFlagSet)) == $past(chFlagSet))); // R9

  AST_FLAG_WR_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((chFlags & $past(chFlags & ~clrMask)) == $past(chFlags & ~clrMask))); // R9

  AST_OVF_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (ovfClr && !strobe.setOvf) |=> !ovfFlag); // R8

  AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setOvf |=> ovfFlag); // R8

endmodule

// File: rtl/presc_timer.sv
module presc_timer
  import presc_timer_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SEL_W      = 3,
  parameter int PRE_STAGES = 5,
  parameter int NUM_CH     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              timerEn,
  input  logic [SEL_W-1:0]  prescaleSel,
  input  logic              cmpResetEn,
  input  logic [CNT_W-1:0]  cmpValue,
  input  logic [NUM_CH-1:0] chFlagSet,
  input  logic [NUM_CH-1:0] chIntEn,
  input  logic              flagWrEn,
  input  logic              ovfWrEn,
  input  logic [NUM_CH-1:0] wrData,
  output logic [CNT_W-1:0]  count,
  output logic              ovfFlag,
  output logic [NUM_CH-1:0] chFlags,
  output logic              irq
);

  tmrStrobe_t strobe;

  presc_timer_ctrl #(
    .CNT_W     (CNT_W),
    .SEL_W     (SEL_W),
    .PRE_STAGES(PRE_STAGES)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .timerEn    (timerEn),
    .prescaleSel(prescaleSel),
    .cmpResetEn (cmpResetEn),
    .cmpValue   (cmpValue),
    .count      (count),
    .strobe     (strobe)
  );

  presc_timer_dp #(
    .CNT_W (CNT_W),
    .NUM_CH(NUM_CH)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .chFlagSet(chFlagSet),
    .chIntEn  (chIntEn),
    .flagWrEn (flagWrEn),
    .ovfWrEn  (ovfWrEn),
    .wrData   (wrData),
    .count    (count),
    .ovfFlag  (ovfFlag),
    .chFlags  (chFlags),
    .irq      (irq)
  );

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !timerEn |=> $stable(count)); // R11

  AST_CMP_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && cmpResetEn && count == cmpValue) |=> (count == '0)); // R4

  AST_CMP_ZERO_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    (cmpResetEn && cmpValue == '0 && count == '0) |=> (count == '0)); // R5

  AST_FULL_CMP_NO_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (cmpResetEn && cmpValue == '1 && count == '1 && !ovfFlag && !(|chFlagSet & 1'b0))
      |=> !ovfFlag); // R6

  AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !cmpResetEn && count == '1) |=> (ovfFlag && count == '0)); // R7

endmodule

// File: tb/test_presc_timer.sv
module test_presc_timer;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 195000;

  // Vector table: upper byte = select code, lower byte = ticks per 64 clocks.
  localparam logic [15:0] VEC [0:7] = '{
    16'h0040, 16'h0120, 16'h0210, 16'h0308,
    16'h0404, 16'h0502, 16'h0602, 16'h0702
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        timerEn = 1'b0;
  logic [2:0]  prescaleSel = '0;
  logic        cmpResetEn = 1'b0;
  logic [15:0] cmpValue = '0;
  logic [7:0]  chFlagSet = '0;
  logic [7:0]  chIntEn = '0;
  logic        flagWrEn = 1'b0;
  logic        ovfWrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [15:0] count;
  logic        ovfFlag;
  logic [7:0]  chFlags;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int edgeCount = 0;
  int cycles = 0;

  presc_timer i_presc_timer (
    .clk(clk), .rstN(rstN), .timerEn(timerEn), .prescaleSel(prescaleSel),
    .cmpResetEn(cmpResetEn), .cmpValue(cmpValue), .chFlagSet(chFlagSet),
    .chIntEn(chIntEn), .flagWrEn(flagWrEn), .ovfWrEn(ovfWrEn), .wrData(wrData),
    .count(count), .ovfFlag(ovfFlag), .chFlags(chFlags), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (rstN) edgeCount++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    edgeCount = 0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait (cycles > WATCHDOG);
    failures++;
    $display("FAIL watchdog actual=0x%0h expected=0x%0h", cycles, WATCHDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] snap;
    logic [15:0] prev;
    bit          seen;
    bit          bad;

    doReset();
    // R1: reset state
    check(count == 16'h0, "R1 count", count, 0);
    check(ovfFlag == 1'b0, "R1 ovf", ovfFlag, 0);
    check(chFlags == 8'h0, "R1 flags", chFlags, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);

    // R3: select change deferred until prescaler returns to zero
    timerEn = 1'b1;
    waitCycles(40);
    while ((edgeCount % 32) != 4) @(negedge clk);
    prescaleSel = 3'd3;
    snap = count;
    waitCycles(10);
    check((count - snap) == 16'd10, "R3 old factor kept", count - snap, 10);

    // R2: vector table of prescale codes
    for (int v = 0; v < 8; v++) begin
      prescaleSel = VEC[v][10:8];
      waitCycles(40);
      snap = count;
      waitCycles(64);
      check((count - snap) == 16'(VEC[v][7:0]), $sformatf("R2 code %0d", v),
            count - snap, VEC[v][7:0]);
    end

    // R11: enable low holds the count
    prescaleSel = 3'd0;
    waitCycles(40);
    timerEn = 1'b0;
    @(negedge clk);
    snap = count;
    waitCycles(20);
    check(count == snap, "R11 hold", count, snap);
    timerEn = 1'b1;

    // R9 / R10: channel flags and interrupt
    doReset();
    chFlagSet = 8'hA5;
    @(negedge clk);
    chFlagSet = 8'h00;
    @(negedge clk);
    check(chFlags == 8'hA5, "R9 set", chFlags, 8'hA5);
    chIntEn = 8'h00; #1;
    check(irq == 1'b0, "R10 masked", irq, 0);
    chIntEn = 8'h04; #1;
    check(irq == 1'b1, "R10 enabled", irq, 1);
    chIntEn = 8'h02; #1;
    check(irq == 1'b0, "R10 other bit", irq, 0);
    @(negedge clk);
    flagWrEn = 1'b1; wrData = 8'h81;
    @(negedge clk);
    flagWrEn = 1'b0; wrData = 8'h00;
    check(chFlags == 8'h24, "R9 clear ones", chFlags, 8'h24);
    flagWrEn = 1'b1; wrData = 8'h00;
    @(negedge clk);
    flagWrEn = 1'b0;
    check(chFlags == 8'h24, "R9 write zero", chFlags, 8'h24);
    flagWrEn = 1'b1; wrData = 8'h04; chFlagSet = 8'h04;
    @(negedge clk);
    flagWrEn = 1'b0; wrData = 8'h00; chFlagSet = 8'h00;
    check(chFlags == 8'h24, "R9 set wins", chFlags, 8'h24);
    chIntEn = 8'h00;

    // R4: compare reset at value 5
    cmpValue = 16'd5; cmpResetEn = 1'b1; prescaleSel = 3'd0;
    doReset();
    bad = 1'b0; seen = 1'b0; prev = count;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (count > 16'd5) bad = 1'b1;
      if (prev == 16'd5) begin
        seen = 1'b1;
        if (count != 16'd0) bad = 1'b1;
      end
      prev = count;
    end
    check(!bad && seen, "R4 modulus", {bad, seen}, 2'b01);

    // R5: compare value zero pins the counter
    cmpValue = 16'd0;
    doReset();
    bad = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (count != 16'd0) bad = 1'b1;
    end
    check(!bad, "R5 stuck at zero", count, 0);

    // R6: compare value all ones, wrap without overflow
    cmpValue = 16'hFFFF;
    doReset();
    seen = 1'b0; prev = count;
    for (int i = 0; i < 65600 && !seen; i++) begin
      @(negedge clk);
      if (prev == 16'hFFFF && count == 16'h0) seen = 1'b1;
      prev = count;
    end
    check(seen, "R6 wrap reached", seen, 1);
    check(ovfFlag == 1'b0, "R6 no overflow", ovfFlag, 0);

    // R7: natural wrap sets overflow
    cmpResetEn = 1'b0; cmpValue = 16'd5;
    doReset();
    seen = 1'b0; prev = count;
    for (int i = 0; i < 65600 && !seen; i++) begin
      @(negedge clk);
      if (prev == 16'hFFFF && count == 16'h0) begin
        seen = 1'b1;
        check(ovfFlag == 1'b1, "R7 overflow set", ovfFlag, 1);
      end
      prev = count;
    end
    check(seen, "R7 wrap reached", seen, 1);

    // R8: overflow write-one-to-clear on data bit 7
    ovfWrEn = 1'b1; wrData = 8'h7F;
    @(negedge clk);
    ovfWrEn = 1'b0; wrData = 8'h00;
    check(ovfFlag == 1'b1, "R8 bit7 zero keeps", ovfFlag, 1);
    ovfWrEn = 1'b1; wrData = 8'h80;
    @(negedge clk);
    ovfWrEn = 1'b0; wrData = 8'h00;
    check(ovfFlag == 1'b0, "R8 bit7 one clears", ovfFlag, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule